// File: doc/BRIEF.md
# SPI Master Interrupt Status and Mask Unit

This unit gathers the interrupt causes of an SPI master controller into one status word and drives a single level-sensitive interrupt line. Three causes are one-cycle event pulses from the transfer engine: transmit queue ran dry, receive queue overrun and mode fault. Each of them is caught into a sticky bit that software clears by writing a one to it. The other four causes are levels. They are recomputed every cycle from the transmit and receive queue fill counts, the queue full flags and two programmable 8-bit thresholds.

Software reaches the unit through a small word-addressed register port. Word address 0 is the status word, and writing ones there clears sticky bits. Address 1 sets mask bits and address 2 clears them; both read as zero. Address 3 is the mask, which is read-only. Addresses 4 and 5 hold the transmit and receive thresholds. The interrupt line is registered. It follows the OR of (mask AND status) with one cycle of delay.

Top module: `spi_irq_agg`

## Requirements
- R1: The status word has these bit positions: 6 transmit underrun, 5 receive full, 4 receive at-threshold, 3 transmit full, 2 transmit below-threshold, 1 mode fault, 0 receive overrun. Out of reset with empty queues and no full flags it reads 0x04.
- R2: A one-cycle pulse on an event input sets its sticky status bit (6, 1 or 0) after the next rising edge. The bit stays set while no clear is written.
- R3: A write to address 0 clears exactly the sticky bits whose data bits are 1. Writing 0 to a bit leaves that bit unchanged.
- R4: When an event pulse and a clear of the same bit fall on the same edge, the bit stays set.
- R5: Status bit 4 is high exactly when the receive fill count is greater than or equal to the receive threshold (address 5).
- R6: Status bit 2 is high exactly when the transmit fill count is strictly less than the transmit threshold (address 4).
- R7: Status bits 5 and 3 follow the receive and transmit full flags in the same cycle and are not sticky.
- R8: A write to address 1 ORs data bits [6:0] into the mask, and a write to address 2 clears them from it. Addresses 1 and 2 read as 0. A write to address 3 leaves the mask unchanged.
- R9: The interrupt output equals the OR of (mask AND status) as it stood in the previous cycle.
- R10: After reset both thresholds read 1, the mask is 0, the sticky bits are 0 and the interrupt output is 0.
- R11: Thresholds keep only data bits [7:0] of a write and read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txCount | input | CNT_W | Transmit queue fill count |
| rxCount | input | CNT_W | Receive queue fill count |
| txFull | input | 1 | Transmit queue full flag |
| rxFull | input | 1 | Receive queue full flag |
| txUnderrunEv | input | 1 | Pulse: transmit queue read while empty |
| rxOverrunEv | input | 1 | Pulse: receive byte dropped on full queue |
| modeFaultEv | input | 1 | Pulse: mode fault detected |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational from regAddr) |
| statusWord | output | 7 | Current status word |
| maskWord | output | 7 | Current interrupt mask |
| irqOut | output | 1 | Registered level interrupt |

## Verification
The bench sweeps both fill counts across the whole counter range against thresholds of 0, 1, 7, 32 and 255. A comparison written with the wrong strictness would show up as a wrong bit exactly at count equal to threshold. It drives all 128 mask patterns and checks the interrupt each time. It also places an event pulse and a clear of the same bit on one edge; a design that lets the clear win would lose that event. Finally, it checks the one-cycle lag of the interrupt in both directions and checks that writes to the set, clear and read-only mask addresses touch only what they should.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_BITS = 7;

  localparam int BIT_TX_UNDER  = 6;
  localparam int BIT_RX_FULL   = 5;
  localparam int BIT_RX_LEVEL  = 4;
  localparam int BIT_TX_FULL   = 3;
  localparam int BIT_TX_LEVEL  = 2;
  localparam int BIT_MODE_FLT  = 1;
  localparam int BIT_RX_OVER   = 0;

  localparam logic [NUM_BITS-1:0] STICKY_BITS =
    NUM_BITS'((1 << BIT_TX_UNDER) | (1 << BIT_MODE_FLT) | (1 << BIT_RX_OVER));

  localparam int ADR_STATUS   = 0;
  localparam int ADR_MASK_SET = 1;
  localparam int ADR_MASK_CLR = 2;
  localparam int ADR_MASK     = 3;
  localparam int ADR_TX_THR   = 4;
  localparam int ADR_RX_THR   = 5;

  typedef struct packed {
    logic clrStatus;
    logic setMask;
    logic clrMask;
    logic wrTxThr;
    logic wrRxThr;
  } irq_strobe_t;
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output irq_strobe_t       strobes
);
  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      case (int'(regAddr))
        ADR_STATUS:   strobes.clrStatus = 1'b1;
        ADR_MASK_SET: strobes.setMask   = 1'b1;
        ADR_MASK_CLR: strobes.clrMask   = 1'b1;
        ADR_TX_THR:   strobes.wrTxThr   = 1'b1;
        ADR_RX_THR:   strobes.wrRxThr   = 1'b1;
        default:      strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_irq_dp.sv
module spi_irq_dp
  import spi_irq_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int THR_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  irq_strobe_t         strobes,
  input  logic [CNT_W-1:0]    txCount,
  input  logic [CNT_W-1:0]    rxCount,
  input  logic                txFull,
  input  logic                rxFull,
  input  logic                txUnderrunEv,
  input  logic                rxOverrunEv,
  input  logic                modeFaultEv,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [NUM_BITS-1:0] statusWord,
  output logic [NUM_BITS-1:0] maskWord,
  output logic                irqOut
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [THR_W-1:0]    txThrQ, rxThrQ;
  logic [NUM_BITS-1:0] stickyQ, stickyNext, evVec, clrVec, liveVec;
  logic [NUM_BITS-1:0] maskQ, wrBits;
  logic [CMP_W-1:0]    txCntExt, rxCntExt, txThrExt, rxThrExt;
  logic                irqQ;
  logic                unusedWrBits;

  assign unusedWrBits = ^regWrData;
  assign wrBits   = regWrData[NUM_BITS-1:0];
  assign txCntExt = CMP_W'(txCount);
  assign rxCntExt = CMP_W'(rxCount);
  assign txThrExt = CMP_W'(txThrQ);
  assign rxThrExt = CMP_W'(rxThrQ);

  always_comb begin
    evVec = '0;
    evVec[BIT_TX_UNDER] = txUnderrunEv;
    evVec[BIT_MODE_FLT] = modeFaultEv;
    evVec[BIT_RX_OVER]  = rxOverrunEv;
    liveVec = '0;
    liveVec[BIT_RX_FULL]  = rxFull;
    liveVec[BIT_TX_FULL]  = txFull;
    liveVec[BIT_RX_LEVEL] = (rxCntExt >= rxThrExt);
    liveVec[BIT_TX_LEVEL] = (txCntExt <  txThrExt);
  end

  assign clrVec     = strobes.clrStatus ? wrBits : '0;
  assign stickyNext = ((stickyQ & ~clrVec) | evVec) & STICKY_BITS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ <= '0;
      maskQ   <= '0;
      txThrQ  <= THR_W'(1);
      rxThrQ  <= THR_W'(1);
      irqQ    <= 1'b0;
    end else begin
      stickyQ <= stickyNext;
      if (strobes.setMask)      maskQ <= maskQ | wrBits;
      else if (strobes.clrMask) maskQ <= maskQ & ~wrBits;
      if (strobes.wrTxThr) txThrQ <= regWrData[THR_W-1:0];
      if (strobes.wrRxThr) rxThrQ <= regWrData[THR_W-1:0];
      irqQ <= |(maskQ & statusWord);
    end
  end

  assign statusWord = stickyQ | liveVec;
  assign maskWord   = maskQ;
  assign irqOut     = irqQ;

  always_comb begin
    case (int'(regAddr))
      ADR_STATUS: regRdData = DATA_W'(statusWord);
      ADR_MASK:   regRdData = DATA_W'(maskQ);
      ADR_TX_THR: regRdData = DATA_W'(txThrQ);
      ADR_RX_THR: regRdData = DATA_W'(rxThrQ);
      default:    regRdData = '0;
    endcase
  end

  // R2
  underrun_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrunEv |=> statusWord[BIT_TX_UNDER]);

  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrStatus && wrBits[BIT_RX_OVER] && !rxOverrunEv) |=> !statusWord[BIT_RX_OVER]);

  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrStatus && wrBits[BIT_MODE_FLT] && modeFaultEv) |=> statusWord[BIT_MODE_FLT]);

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.setMask && !strobes.clrMask) |=> $stable(maskWord));

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(maskWord & statusWord)) |=> irqOut);

  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|(maskWord & statusWord)) |=> !irqOut);
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import spi_irq_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int THR_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    txCount,
  input  logic [CNT_W-1:0]    rxCount,
  input  logic                txFull,
  input  logic                rxFull,
  input  logic                txUnderrunEv,
  input  logic                rxOverrunEv,
  input  logic                modeFaultEv,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic [NUM_BITS-1:0] statusWord,
  output logic [NUM_BITS-1:0] maskWord,
  output logic                irqOut
);
  irq_strobe_t strobes;

  spi_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  spi_irq_dp #(
    .CNT_W(CNT_W), .THR_W(THR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .txCount      (txCount),
    .rxCount      (rxCount),
    .txFull       (txFull),
    .rxFull       (rxFull),
    .txUnderrunEv (txUnderrunEv),
    .rxOverrunEv  (rxOverrunEv),
    .modeFaultEv  (modeFaultEv),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .statusWord   (statusWord),
    .maskWord     (maskWord),
    .irqOut       (irqOut)
  );
endmodule

// File: tb/spi_irq_agg_bench.sv
module spi_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] txCount = '0, rxCount = '0;
  logic txFull = 1'b0, rxFull = 1'b0;
  logic txUnderrunEv = 1'b0, rxOverrunEv = 1'b0, modeFaultEv = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [6:0] statusWord, maskWord;
  logic irqOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_agg #(.CNT_W(CNT_W)) u_spi_irq_agg (
    .clk(clk), .rstN(rstN), .txCount(txCount), .rxCount(rxCount),
    .txFull(txFull), .rxFull(rxFull), .txUnderrunEv(txUnderrunEv),
    .rxOverrunEv(rxOverrunEv), .modeFaultEv(modeFaultEv),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .statusWord(statusWord), .maskWord(maskWord),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = 3'(a);
    #1 d = regRdData;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    txUnderrunEv = (which == 6);
    modeFaultEv  = (which == 1);
    rxOverrunEv  = (which == 0);
    @(negedge clk);
    txUnderrunEv = 1'b0; modeFaultEv = 1'b0; rxOverrunEv = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int thrList [5] = '{0, 1, 7, 32, 255};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 / R1 reset state
    check("R1 reset status", 32'(statusWord), 32'h04);
    check("R10 mask", 32'(maskWord), 32'h0);
    check("R10 irq", 32'(irqOut), 32'h0);
    rdReg(4, rd); check("R10 tx thr", rd, 32'd1);
    rdReg(5, rd); check("R10 rx thr", rd, 32'd1);

    // R5 R6 threshold sweeps
    foreach (thrList[k]) begin
      wrReg(4, 32'(thrList[k]));
      wrReg(5, 32'(thrList[k]));
      for (int c = 0; c < (1 << CNT_W); c++) begin
        @(negedge clk);
        txCount = CNT_W'(c); rxCount = CNT_W'(c);
        #1;
        check("R5 rx level", 32'(statusWord[4]), 32'(c >= thrList[k]));
        check("R6 tx level", 32'(statusWord[2]), 32'(c < thrList[k]));
      end
    end
    // R11 threshold width
    wrReg(4, 32'h1A5); rdReg(4, rd); check("R11 tx thr width", rd, 32'hA5);
    wrReg(5, 32'hF03); rdReg(5, rd); check("R11 rx thr width", rd, 32'h03);
    wrReg(4, 32'd1); wrReg(5, 32'd1);
    @(negedge clk); txCount = 6'd5; rxCount = 6'd0;

    // R7 full flags live
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      txFull = f[0]; rxFull = f[1];
      #1;
      check("R7 tx full", 32'(statusWord[3]), 32'(f[0]));
      check("R7 rx full", 32'(statusWord[5]), 32'(f[1]));
    end
    @(negedge clk); txFull = 1'b0; rxFull = 1'b0;
    #1 check("R7 not sticky", 32'(statusWord), 32'h0);

    // R2 R3 R4 sticky events
    for (int b = 0; b < 7; b++) begin
      if (b == 0 || b == 1 || b == 6) begin
        pulse(b);
        check("R2 event sets", 32'(statusWord), 32'(1 << b));
        repeat (3) @(negedge clk);
        check("R2 event holds", 32'(statusWord), 32'(1 << b));
        wrReg(0, 32'(7'h7F & ~(7'(1) << b)));
        check("R3 other bits no effect", 32'(statusWord), 32'(1 << b));
        wrReg(0, 32'(1 << b));
        check("R3 clear", 32'(statusWord), 32'h0);
        @(negedge clk);
        regWrEn = 1'b1; regAddr = 3'd0; regWrData = 32'(1 << b);
        txUnderrunEv = (b == 6); modeFaultEv = (b == 1); rxOverrunEv = (b == 0);
        @(negedge clk);
        regWrEn = 1'b0; txUnderrunEv = 1'b0; modeFaultEv = 1'b0; rxOverrunEv = 1'b0;
        check("R4 event wins", 32'(statusWord), 32'(1 << b));
        wrReg(0, 32'h7F);
        check("R3 clear after R4", 32'(statusWord), 32'h0);
      end
    end

    // R8 mask registers
    wrReg(1, 32'h05); check("R8 set", 32'(maskWord), 32'h05);
    wrReg(1, 32'h40); check("R8 set or", 32'(maskWord), 32'h45);
    wrReg(2, 32'h01); check("R8 clear", 32'(maskWord), 32'h44);
    wrReg(3, 32'h7F); check("R8 read-only", 32'(maskWord), 32'h44);
    rdReg(1, rd); check("R8 set reads 0", rd, 32'h0);
    rdReg(2, rd); check("R8 clr reads 0", rd, 32'h0);
    rdReg(3, rd); check("R8 mask read", rd, 32'h44);

    // R9 registered interrupt
    @(negedge clk); check("R9 idle", 32'(irqOut), 32'h0);
    txCount = 6'd0;
    #1 check("R9 lag rise", 32'(irqOut), 32'h0);
    @(negedge clk); check("R9 rise", 32'(irqOut), 32'h1);
    wrReg(2, 32'h04);
    check("R9 lag fall", 32'(irqOut), 32'h1);
    @(negedge clk); check("R9 fall", 32'(irqOut), 32'h0);
    pulse(6);
    check("R9 lag event", 32'(irqOut), 32'h0);
    @(negedge clk); check("R9 event irq", 32'(irqOut), 32'h1);
    wrReg(0, 32'h40);
    @(negedge clk); check("R9 cleared irq", 32'(irqOut), 32'h0);

    // R9 R8 mask sweep against status 0x04
    for (int m = 0; m < 128; m++) begin
      wrReg(2, 32'h7F);
      wrReg(1, 32'(m));
      check("R8 mask sweep", 32'(maskWord), 32'(m));
      @(negedge clk);
      check("R9 mask sweep", 32'(irqOut), 32'((m & 4) != 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule